// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM and brings the memory from power-on to the point where normal commands may be issued. It keeps the clock enable low until an external stable-power indication is seen. It then waits for a programmable start-up delay, counted in clock cycles. After that it raises the clock enable and steps through the fixed initialization sequence. Between two commands it inserts spacing that is set by parameters.

The sequence runs in this order:
- a no-operation;
- a precharge of all banks;
- a load of the extended mode register, which keeps the DLL enabled;
- a load of the base mode register with the DLL reset bit set;
- a long idle wait for DLL lock;
- a second precharge-all;
- two auto refreshes;
- a final load of the base mode register with the DLL reset bit cleared.

Once that last spacing has elapsed, a ready flag is raised. The flag stays high until reset. Periods without a command drive deselect, so chip select is high.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and on its release, the outputs are: cke=0, cmd=4'b1111 (deselect, where cmd is {cs_n, ras_n, cas_n, we_n}), ba=0, addr=0 and done=0.
- R2: Until the start-up delay has expired, cke stays 0 and cmd stays deselect (1111).
- R3: A NOP (cmd 0111) appears together with cke=1 exactly INIT_WAIT cycles after the first clock edge that samples pwr_ok high. If pwr_ok is sampled low at any edge up to and including that one, the delay is abandoned and restarts from the next edge that samples pwr_ok high.
- R4: The eight commands appear in this fixed order:
  - NOP;
  - precharge (0010) with addr bit 10 = 1 and ba=0;
  - mode register set (0000) with ba=01 and addr=EMR_OPS, with bit 0 (DLL disable) forced to 0;
  - mode register set with ba=00 and addr=MR_OPS, with bit 8 (DLL reset) forced to 1;
  - precharge-all;
  - auto refresh (0001);
  - auto refresh;
  - mode register set with ba=00 and addr=MR_OPS, with bit 8 forced to 0.

  No other command appears.
- R5: The distance in cycles from each command to the next is as follows:
  - NOP to the next command: 1;
  - precharge to the next command: T_RP;
  - extended mode register set to the next command: T_MRD;
  - DLL-reset mode register set to the second precharge: the larger of DLL_WAIT and T_MRD;
  - each auto refresh to the next command: T_RFC.
- R6: Every cycle without a command carries cmd=1111 with ba=0 and addr=0.
- R7: done rises exactly T_MRD cycles after the final mode register set and stays 1 until reset. While done is 1, cmd is deselect.
- R8: Once the NOP has been issued, pwr_ok has no effect on the sequence or on done.
- R9: Once raised with the NOP, cke stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supplies, reference voltage and clock are stable |
| cke | output | 1 | Clock enable to the memory |
| cmd | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus / mode register payload |
| done | output | 1 | Initialization complete, sticky until reset |

## Verification
A wrong step index or spacing count shows at the ports as one of the following, on the very cycle it happens:
- a command that arrives too early or too late;
- a command with the wrong encoding;
- a mode register payload with the DLL bits in the wrong state.

The bench predicts every output on every cycle from a schedule built in the bench. Any slip is therefore reported on the first cycle where a command is misplaced. A counter that leaves the start-up delay early makes cke rise before INIT_WAIT. A ready flag that is not held, or a stray command after completion, is seen one cycle later.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int INIT_WAIT = 40000,
  parameter int DLL_WAIT  = 200,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 14,
  parameter logic [ADDR_W-1:0] MR_OPS  = 'h032,
  parameter logic [ADDR_W-1:0] EMR_OPS = 'h000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  localparam int GAP_DLL = (DLL_WAIT > T_MRD) ? DLL_WAIT : T_MRD;
  localparam int M1   = (INIT_WAIT > GAP_DLL) ? INIT_WAIT : GAP_DLL;
  localparam int M2   = (T_RFC > T_RP) ? T_RFC : T_RP;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(MAXC + 1);

  localparam logic [3:0] C_DES = 4'b1111;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] STEPS = 4'd8;

  localparam logic [ADDR_W-1:0] A_ALLBK  = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] A_DLLRST = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] A_EMR    = EMR_OPS & ~ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MR_RST = MR_OPS | A_DLLRST;
  localparam logic [ADDR_W-1:0] A_MR_RUN = MR_OPS & ~A_DLLRST;

  typedef enum logic [1:0] {PH_PWR, PH_DLY, PH_SEQ, PH_DONE} phase_t;

  phase_t            ph;
  logic [3:0]        step;
  logic [CNT_W-1:0]  cnt;
  logic [3:0]        s_cmd;
  logic [BA_W-1:0]   s_ba;
  logic [ADDR_W-1:0] s_addr;
  logic [CNT_W-1:0]  s_gap;

  always_comb begin
    s_cmd  = C_DES;
    s_ba   = '0;
    s_addr = '0;
    s_gap  = CNT_W'(1);
    case (step)
      4'd0: s_cmd = C_NOP;
      4'd1: begin s_cmd = C_PRE; s_addr = A_ALLBK; s_gap = CNT_W'(T_RP); end
      4'd2: begin s_cmd = C_MRS; s_ba = BA_W'(1); s_addr = A_EMR; s_gap = CNT_W'(T_MRD); end
      4'd3: begin s_cmd = C_MRS; s_addr = A_MR_RST; s_gap = CNT_W'(GAP_DLL); end
      4'd4: begin s_cmd = C_PRE; s_addr = A_ALLBK; s_gap = CNT_W'(T_RP); end
      4'd5: begin s_cmd = C_REF; s_gap = CNT_W'(T_RFC); end
      4'd6: begin s_cmd = C_REF; s_gap = CNT_W'(T_RFC); end
      4'd7: begin s_cmd = C_MRS; s_addr = A_MR_RUN; s_gap = CNT_W'(T_MRD); end
      default: ;
    endcase
  end

  wire go = (cnt == '0) &&
            ((ph == PH_DLY && pwr_ok) || (ph == PH_SEQ && step != STEPS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_PWR;
      step <= '0;
      cnt  <= '0;
      cke  <= 1'b0;
      cmd  <= C_DES;
      ba   <= '0;
      addr <= '0;
      done <= 1'b0;
    end else begin
      cmd  <= C_DES;
      ba   <= '0;
      addr <= '0;
      case (ph)
        PH_PWR: if (pwr_ok) begin
          ph  <= PH_DLY;
          cnt <= CNT_W'(INIT_WAIT - 1);
        end
        PH_DLY: begin
          if (!pwr_ok) ph <= PH_PWR;
          else if (cnt != '0) cnt <= cnt - CNT_W'(1);
          else begin
            ph  <= PH_SEQ;
            cke <= 1'b1;
          end
        end
        PH_SEQ: begin
          if (cnt != '0) cnt <= cnt - CNT_W'(1);
          else if (step == STEPS) begin
            ph   <= PH_DONE;
            done <= 1'b1;
          end
        end
        default: ;
      endcase
      if (go) begin
        cmd  <= s_cmd;
        ba   <= s_ba;
        addr <= s_addr;
        cnt  <= s_gap - CNT_W'(1);
        step <= step + 4'd1;
      end
    end
  end

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic [3:0]        cmd,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              done
);

  a_r2_des_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cmd == 4'b1111);

  a_r3_nop_with_cke: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0111 |-> cke);

  a_r4_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0010 |-> addr[10] && ba == '0);

  a_r4_mrs_base_or_ext: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0000 |-> ba < BA_W'(2));

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b1111 |-> addr == '0 && ba == '0);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd == 4'b1111 && cke);

  a_r9_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .ba(ba), .addr(addr), .done(done)
);

// File: tb/ddr_init_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_init_seq_tb_top;
  localparam int AW  = 13;
  localparam int IW  = 20;
  localparam int DW  = 30;
  localparam int RP  = 3;
  localparam int MRD = 2;
  localparam int RFC = 7;
  localparam logic [AW-1:0] MR  = 13'h032;
  localparam logic [AW-1:0] EMR = 13'h003;

  logic clk = 0, rst_n = 0, pwr_ok = 0;
  logic cke, done;
  logic [3:0] cmd;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  int tests = 0, fails = 0;

  ddr_init_seq #(.ADDR_W(AW), .BA_W(2), .INIT_WAIT(IW), .DLL_WAIT(DW), .T_RP(RP),
                 .T_MRD(MRD), .T_RFC(RFC), .MR_OPS(MR), .EMR_OPS(EMR)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .cke(cke), .cmd(cmd),
    .ba(ba), .addr(addr), .done(done));

  always #2.5 clk = ~clk;

  // expected command list from R4, spacing from R5
  logic [3:0]    e_cmd [8] = '{4'b0111, 4'b0010, 4'b0000, 4'b0000, 4'b0010, 4'b0001, 4'b0001, 4'b0000};
  logic [1:0]    e_ba  [8] = '{2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
  logic [AW-1:0] e_addr[8] = '{13'h000, 13'h400, 13'h002, 13'h132, 13'h400, 13'h000, 13'h000, 13'h032};
  int            e_gap [8] = '{1, RP, MRD, DW, RP, RFC, RFC, MRD};

  int en = 0, t_done = 0;
  int t_ev[8];
  bit started = 0;
  logic x_cke, x_done;
  logic [3:0] x_cmd;
  logic [1:0] x_ba;
  logic [AW-1:0] x_addr;
  int n_nop, n_pre, n_mrs, n_ref;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      en = 0; started = 0;
    end else begin
      en++;
      if (started && en <= t_ev[0] && !pwr_ok) started = 0;      // R3 restart
      else if (!started && pwr_ok) begin
        started = 1;
        t_ev[0] = en + IW;
        for (int k = 1; k < 8; k++) t_ev[k] = t_ev[k-1] + e_gap[k-1];
        t_done = t_ev[7] + MRD;
      end
    end
    x_cmd = 4'b1111; x_ba = 0; x_addr = 0;
    x_cke = started && en >= t_ev[0];
    x_done = started && en >= t_done;
    if (started)
      for (int k = 0; k < 8; k++)
        if (en == t_ev[k]) begin x_cmd = e_cmd[k]; x_ba = e_ba[k]; x_addr = e_addr[k]; end
    #1;
    begin
      string tg;
      if (!rst_n) tg = "R1";
      else if (x_done) tg = "R7";
      else if (!x_cke) tg = "R2";
      else if (x_cmd == 4'b1111) tg = "R6";
      else tg = "R5";
      check({tg, " cke"}, 32'(cke), 32'(x_cke));          // R9 R8
      check({tg, " cmd"}, 32'(cmd), 32'(x_cmd));          // R4 R5
      check({tg, " ba/addr"}, {14'd0, ba, 3'd0, addr}, {14'd0, x_ba, 3'd0, x_addr});
      check({tg, " done"}, 32'(done), 32'(x_done));
    end
    if (rst_n) case (cmd)
      4'b0111: n_nop++;
      4'b0010: n_pre++;
      4'b0000: n_mrs++;
      4'b0001: n_ref++;
      default: ;
    endcase
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_to_done();
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    cyc(15);
  endtask

  initial begin
    cyc(3);
    // R1 reset values
    check("R1 cke", 32'(cke), 0);
    check("R1 cmd", 32'(cmd), 32'hF);
    check("R1 done", 32'(done), 0);
    rst_n = 1;
    n_nop = 0; n_pre = 0; n_mrs = 0; n_ref = 0;
    cyc(6);                       // R2 waiting for power
    pwr_ok = 1; cyc(8);
    pwr_ok = 0; cyc(3);           // R3 abandon delay
    pwr_ok = 1; cyc(IW + 12);
    pwr_ok = 0; cyc(5);           // R8 ignored after start
    pwr_ok = 1;
    run_to_done();
    check("R7 done held", 32'(done), 1);
    check("R4 nop count", 32'(n_nop), 1);
    check("R4 pre count", 32'(n_pre), 2);
    check("R4 mrs count", 32'(n_mrs), 3);
    check("R4 ref count", 32'(n_ref), 2);
    // second run: reset mid sequence
    rst_n = 0; cyc(2); rst_n = 1;
    n_nop = 0; n_pre = 0; n_mrs = 0; n_ref = 0;
    cyc(IW + 25);
    rst_n = 0; #1;
    check("R1 async cke", 32'(cke), 0);
    check("R1 async cmd", 32'(cmd), 32'hF);
    check("R1 async addr", 32'(addr), 0);
    cyc(2); rst_n = 1;
    n_nop = 0; n_pre = 0; n_mrs = 0; n_ref = 0;
    run_to_done();
    check("R7 done second", 32'(done), 1);
    check("R4 ref count second", 32'(n_ref), 2);
    check("R4 mrs count second", 32'(n_mrs), 3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule